// File: doc/BRIEF.md
# Multi-Region Execution Time Profiler

This block watches the stream of retired instruction addresses of a processor and measures how much activity falls inside three code regions. Each region is bounded by a programmable entry address and exit address. A region turns active when an instruction at its entry address retires and turns inactive when an instruction at its exit address retires. While a region is active, its measure accumulator advances. Depending on a global mode, it counts either retired instructions or clock cycles. In cycle mode the clock passes through a power-of-two prescaler first, selectable from /1 to /32. A second counter per region records how many times the region was entered.

Software starts, stops and clears the profiler with single-cycle pulses. It can also arm an automatic start that fires when the processor comes out of reset. Results can be read through a small read port only while the profiler is stopped. While it runs, the port returns zero and flags the data as not valid. Entry and exit addresses of a region are expected to lie at least three instructions apart.

Top module: `exec_region_profiler`

## Requirements
- R1: After reset the profiler is stopped, `rd_valid_o` is 1 and every region reads 0 for both the measure (`rd_what_i`=0) and the entry count (`rd_what_i`=1).
- R2: While running, a retire whose PC equals a region's entry address makes that region active from the next cycle and adds 1 to its entry count.
- R3: While running, a retire whose PC equals a region's exit address, and not its entry address, makes the region inactive from the next cycle. The exit retire itself is still counted in instruction mode.
- R4: With `mode_i`=1 (instruction mode), an active region's measure goes up by 1 for each retire. The retire at the entry address is not counted. Cycles without a retire add nothing.
- R5: With `mode_i`=0 (cycle mode), an active region's measure goes up once every 2^`div_sel_i` cycles, driven by a free-running 5-bit prescaler. Values 5, 6 and 7 all select /32.
- R6: Measure and entry counters saturate at all ones and never wrap.
- R7: While running, `rd_valid_o` is 0 and `rd_data_o` is 0. While stopped, `rd_valid_o` is 1 and `rd_data_o` shows the selected counter.
- R8: A `clear_i` pulse zeroes all counters, active flags and the prescaler in one cycle. A start in the same cycle is ignored.
- R9: When `auto_start_i` is 1, a rising edge on `cpu_rst_n_i` starts the profiler. When `auto_start_i` is 0, the rising edge has no effect.
- R10: While stopped, retires do not change any counter or active flag.
- R11: Regions operate independently, so nested or overlapping regions each accumulate their own activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| retire_pc_i | input | AW | Address of the retiring instruction |
| region_entry_i | input | NREG*AW | Entry addresses, region n at bits [n*AW +: AW] |
| region_exit_i | input | NREG*AW | Exit addresses, same packing |
| mode_i | input | 1 | 0 = count prescaled cycles, 1 = count instructions |
| div_sel_i | input | 3 | Prescaler select, divide by 2^value, capped at /32 |
| auto_start_i | input | 1 | Start automatically on CPU reset release |
| cpu_rst_n_i | input | 1 | CPU reset, active low; its rising edge is the release |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse, wins over start |
| clear_i | input | 1 | Clear pulse, wins over start |
| rd_region_i | input | RW | Region to read |
| rd_what_i | input | 1 | 0 = measure, 1 = entry count |
| rd_data_o | output | CW | Selected counter, 0 while running |
| rd_valid_o | output | 1 | High when the profiler is stopped |

## Verification
The bench nests one region inside another and checks the entry and exit boundaries. A design that counted the entry retire, or dropped the exit retire, would be off by one in instruction mode. In cycle mode the bench uses windows whose length is a multiple of the divide ratio, and it includes the out-of-range select values. A prescaler with the wrong mask would give too many or too few ticks. The bench also drives more than 2^CW events to expose a counter that wraps. Further checks cover a clear issued together with a start, retires while stopped, and a reset release with auto-start both armed and disarmed. These catch a start that beats clear, state that leaks while stopped, and a spurious auto-start.

// File: rtl/profiler_pkg.sv
`timescale 1ns/1ps
package profiler_pkg;

  localparam int PRESC_W = 5;

  // Mask of prescaler bits that must all be one for a tick; selects above 5 cap at /32.
  function automatic logic [PRESC_W-1:0] div_mask(input logic [2:0] sel);
    logic [PRESC_W-1:0] m;
    if (sel >= 3'd5) m = '1;
    else             m = PRESC_W'((6'd1 << sel) - 6'd1);
    return m;
  endfunction

  function automatic logic presc_tick(input logic [PRESC_W-1:0] cnt, input logic [2:0] sel);
    return (cnt & div_mask(sel)) == div_mask(sel);
  endfunction

endpackage

// File: rtl/prof_prescaler.sv
`timescale 1ns/1ps
module prof_prescaler
  import profiler_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       clear_i,
  input  logic [2:0] div_sel_i,
  output logic       tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = presc_tick(cnt_q, div_sel_i);
endmodule

// File: rtl/prof_region.sv
`timescale 1ns/1ps
module prof_region #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          clear_i,
  input  logic          running_i,
  input  logic          retire_valid_i,
  input  logic [AW-1:0] retire_pc_i,
  input  logic [AW-1:0] entry_addr_i,
  input  logic [AW-1:0] exit_addr_i,
  input  logic          mode_i,
  input  logic          tick_i,
  output logic          active_o,
  output logic          hit_entry_o,
  output logic          hit_exit_o,
  output logic [CW-1:0] measure_o,
  output logic [CW-1:0] entries_o
);
  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  logic          active_q;
  logic [CW-1:0] meas_q, ent_q;
  logic          step;

  assign hit_entry_o = running_i && retire_valid_i && (retire_pc_i == entry_addr_i);
  assign hit_exit_o  = running_i && retire_valid_i && (retire_pc_i == exit_addr_i);
  // Entry retire sees active_q still low; the exit retire sees it still high.
  assign step        = running_i && active_q && (mode_i ? retire_valid_i : tick_i);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      active_q <= 1'b0;
      meas_q   <= '0;
      ent_q    <= '0;
    end else if (clear_i) begin
      active_q <= 1'b0;
      meas_q   <= '0;
      ent_q    <= '0;
    end else begin
      if (hit_entry_o)     active_q <= 1'b1;
      else if (hit_exit_o) active_q <= 1'b0;
      if (hit_entry_o) ent_q  <= sat_inc(ent_q);
      if (step)        meas_q <= sat_inc(meas_q);
    end
  end

  assign active_o  = active_q;
  assign measure_o = meas_q;
  assign entries_o = ent_q;
endmodule

// File: rtl/prof_readout.sv
`timescale 1ns/1ps
module prof_readout #(
  parameter int NREG = 3,
  parameter int CW   = 32,
  parameter int RW   = 2
) (
  input  logic [NREG*CW-1:0] meas_flat_i,
  input  logic [NREG*CW-1:0] ent_flat_i,
  input  logic [RW-1:0]      rd_region_i,
  input  logic               rd_what_i,
  input  logic               running_i,
  output logic [CW-1:0]      rd_data_o,
  output logic               rd_valid_o
);
  logic [CW-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_region_i == RW'(i))
        picked = rd_what_i ? ent_flat_i[i*CW +: CW] : meas_flat_i[i*CW +: CW];
    end
  end

  assign rd_valid_o = !running_i;
  assign rd_data_o  = running_i ? '0 : picked;
endmodule

// File: rtl/exec_region_profiler.sv
`timescale 1ns/1ps
module exec_region_profiler #(
  parameter int NREG = 3,
  parameter int AW   = 32,
  parameter int CW   = 32,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               retire_valid_i,
  input  logic [AW-1:0]      retire_pc_i,
  input  logic [NREG*AW-1:0] region_entry_i,
  input  logic [NREG*AW-1:0] region_exit_i,
  input  logic               mode_i,
  input  logic [2:0]         div_sel_i,
  input  logic               auto_start_i,
  input  logic               cpu_rst_n_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               clear_i,
  input  logic [RW-1:0]      rd_region_i,
  input  logic               rd_what_i,
  output logic [CW-1:0]      rd_data_o,
  output logic               rd_valid_o
);
  logic               running_q;
  logic               cpu_rel_q;
  logic               release_evt;
  logic               start_req;
  logic               tick;
  logic [NREG-1:0]    active;
  logic [NREG-1:0]    hit_entry;
  logic [NREG-1:0]    hit_exit;
  logic [NREG*CW-1:0] meas_flat;
  logic [NREG*CW-1:0] ent_flat;

  assign release_evt = cpu_rst_n_i && !cpu_rel_q;
  assign start_req   = start_i || (auto_start_i && release_evt);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      running_q <= 1'b0;
      cpu_rel_q <= 1'b1;
    end else begin
      cpu_rel_q <= cpu_rst_n_i;
      if (stop_i)                     running_q <= 1'b0;
      else if (start_req && !clear_i) running_q <= 1'b1;
    end
  end

  prof_prescaler u_presc (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .clear_i   (clear_i),
    .div_sel_i (div_sel_i),
    .tick_o    (tick)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_region
    prof_region #(.AW(AW), .CW(CW)) u_region (
      .clk_i          (clk_i),
      .rst_n_i        (rst_n_i),
      .clear_i        (clear_i),
      .running_i      (running_q),
      .retire_valid_i (retire_valid_i),
      .retire_pc_i    (retire_pc_i),
      .entry_addr_i   (region_entry_i[g*AW +: AW]),
      .exit_addr_i    (region_exit_i[g*AW +: AW]),
      .mode_i         (mode_i),
      .tick_i         (tick),
      .active_o       (active[g]),
      .hit_entry_o    (hit_entry[g]),
      .hit_exit_o     (hit_exit[g]),
      .measure_o      (meas_flat[g*CW +: CW]),
      .entries_o      (ent_flat[g*CW +: CW])
    );
  end

  prof_readout #(.NREG(NREG), .CW(CW), .RW(RW)) u_readout (
    .meas_flat_i (meas_flat),
    .ent_flat_i  (ent_flat),
    .rd_region_i (rd_region_i),
    .rd_what_i   (rd_what_i),
    .running_i   (running_q),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o)
  );
endmodule

// File: rtl/exec_region_profiler_chk.sv
`timescale 1ns/1ps
module exec_region_profiler_chk #(
  parameter int NREG = 3,
  parameter int CW   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clear,
  input logic               start,
  input logic               auto_start,
  input logic               running,
  input logic               mode,
  input logic               retire_valid,
  input logic               rd_valid,
  input logic [CW-1:0]      rd_data,
  input logic [NREG-1:0]    active,
  input logic [NREG-1:0]    hit_entry,
  input logic [NREG-1:0]    hit_exit,
  input logic [NREG*CW-1:0] meas_flat,
  input logic [NREG*CW-1:0] ent_flat
);
  a_r7_hidden_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (!rd_valid && rd_data == '0));

  a_r8_clear_beats_start: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && start && !running) |=> !running);

  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (meas_flat == '0 && ent_flat == '0 && active == '0));

  a_r9_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start && !auto_start) |=> !running);

  a_r10_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clear) |=> ($stable(meas_flat) && $stable(ent_flat) && $stable(active)));

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    a_r2_entry_activates: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_entry[g] && !clear) |=> active[g]);

    a_r2_entry_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((ent_flat[g*CW +: CW] - $past(ent_flat[g*CW +: CW])) <= CW'(1)));

    a_r3_exit_deactivates: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_exit[g] && !hit_entry[g] && !clear) |=> !active[g]);

    a_r4_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && !retire_valid && !clear) |=> $stable(meas_flat[g*CW +: CW]));

    a_r6_measure_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_flat[g*CW +: CW] == '1 && !clear) |=> meas_flat[g*CW +: CW] == '1);

    a_r6_entries_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_flat[g*CW +: CW] == '1 && !clear) |=> ent_flat[g*CW +: CW] == '1);
  end
endmodule

bind exec_region_profiler exec_region_profiler_chk #(.NREG(NREG), .CW(CW)) u_chk (
  .clk          (clk_i),
  .rst_n        (rst_n_i),
  .clear        (clear_i),
  .start        (start_i),
  .auto_start   (auto_start_i),
  .running      (running_q),
  .mode         (mode_i),
  .retire_valid (retire_valid_i),
  .rd_valid     (rd_valid_o),
  .rd_data      (rd_data_o),
  .active       (active),
  .hit_entry    (hit_entry),
  .hit_exit     (hit_exit),
  .meas_flat    (meas_flat),
  .ent_flat     (ent_flat)
);

// File: tb/exec_region_profiler_tb_top.sv
`timescale 1ns/1ps
module exec_region_profiler_tb_top;
  localparam int NREG = 3;
  localparam int AW   = 32;
  localparam int CW   = 8;
  localparam int RW   = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               retire_valid = 1'b0;
  logic [AW-1:0]      retire_pc = '0;
  logic [NREG*AW-1:0] region_entry;
  logic [NREG*AW-1:0] region_exit;
  logic               mode = 1'b1;
  logic [2:0]         div_sel = 3'd0;
  logic               auto_start = 1'b0;
  logic               cpu_rst_n = 1'b1;
  logic               start = 1'b0, stop = 1'b0, clear = 1'b0;
  logic [RW-1:0]      rd_region = '0;
  logic               rd_what = 1'b0;
  logic [CW-1:0]      rd_data;
  logic               rd_valid;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  assign region_entry = {32'h0000_0104, 32'h0000_0200, 32'h0000_0100};
  assign region_exit  = {32'h0000_010C, 32'h0000_0210, 32'h0000_0110};

  exec_region_profiler #(.NREG(NREG), .AW(AW), .CW(CW)) dut_i (
    .clk_i (clk), .rst_n_i (rst_n),
    .retire_valid_i (retire_valid), .retire_pc_i (retire_pc),
    .region_entry_i (region_entry), .region_exit_i (region_exit),
    .mode_i (mode), .div_sel_i (div_sel), .auto_start_i (auto_start),
    .cpu_rst_n_i (cpu_rst_n), .start_i (start), .stop_i (stop), .clear_i (clear),
    .rd_region_i (rd_region), .rd_what_i (rd_what),
    .rd_data_o (rd_data), .rd_valid_o (rd_valid)
  );

  typedef struct {
    int    region;
    bit    what;
    int    value;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  // Monitor: pops expected read items and compares against the read port.
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      @(negedge clk);
      rd_region = RW'(sb_q[0].region);
      rd_what   = sb_q[0].what;
      #1;
      tests++;
      if (int'(rd_data) != sb_q[0].value) begin
        fails++;
        $display("FAIL %s region %0d sel %0d: actual %0d expected %0d",
                 sb_q[0].tag, sb_q[0].region, sb_q[0].what, rd_data, sb_q[0].value);
      end
      void'(sb_q.pop_front());
    end
  end

  task automatic expect_rd(input int region, input bit what, input int value, input string tag);
    sb_q.push_back('{region, what, value, tag});
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic check_valid(input bit exp, input string tag);
    tests++;
    if (rd_valid !== exp) begin
      fails++;
      $display("FAIL %s rd_valid: actual %0b expected %0b", tag, rd_valid, exp);
    end
  endtask

  // All drive tasks start and end at a negedge.
  task automatic retire(input logic [AW-1:0] pc);
    retire_valid = 1'b1;
    retire_pc    = pc;
    @(negedge clk);
    retire_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  task automatic pulse_clear();
    clear = 1'b1; @(negedge clk); clear = 1'b0;
  endtask

  task automatic cycle_window(input logic [2:0] sel, input int k, input int exp_meas, input string tag);
    pulse_clear();
    mode    = 1'b0;
    div_sel = sel;
    pulse_start();
    retire(32'h100);
    idle(k);
    retire(32'h110);
    pulse_stop();
    expect_rd(0, 0, exp_meas, tag);
    expect_rd(0, 1, 1, tag);
    drain();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    check_valid(1'b1, "R1");
    for (int r = 0; r < NREG; r++) begin
      expect_rd(r, 0, 0, "R1");
      expect_rd(r, 1, 0, "R1");
    end
    drain();

    // R2 R3 R4 R11: instruction mode, region 2 nested in region 0
    mode = 1'b1;
    pulse_start();
    check_valid(1'b0, "R7");
    retire(32'h100);
    retire(32'h104);
    idle(2);
    retire(32'h108);
    retire(32'h10C);
    retire(32'h110);
    retire(32'h120);
    expect_rd(0, 0, 0, "R7");
    drain();
    check_valid(1'b0, "R7");
    pulse_stop();
    check_valid(1'b1, "R7");
    expect_rd(0, 0, 4, "R4");
    expect_rd(0, 1, 1, "R2");
    expect_rd(2, 0, 2, "R3");
    expect_rd(2, 1, 1, "R11");
    expect_rd(1, 0, 0, "R11");
    drain();

    // R10: retires while stopped change nothing
    retire(32'h200);
    retire(32'h204);
    retire(32'h100);
    retire(32'h104);
    expect_rd(1, 0, 0, "R10");
    expect_rd(1, 1, 0, "R10");
    expect_rd(0, 1, 1, "R10");
    expect_rd(0, 0, 4, "R10");
    drain();

    // R8: clear together with start, start must be ignored
    clear = 1'b1; start = 1'b1;
    @(negedge clk);
    clear = 1'b0; start = 1'b0;
    check_valid(1'b1, "R8");
    expect_rd(0, 0, 0, "R8");
    expect_rd(0, 1, 0, "R8");
    expect_rd(2, 0, 0, "R8");
    drain();

    // R5: cycle mode windows, active for k+1 cycles
    cycle_window(3'd0, 15, 16, "R5");
    cycle_window(3'd2, 15, 4,  "R5");
    cycle_window(3'd5, 63, 2,  "R5");
    cycle_window(3'd7, 63, 2,  "R5");

    // R6: saturation of measure and entry count
    pulse_clear();
    mode = 1'b1;
    pulse_start();
    for (int n = 0; n < 260; n++) begin
      retire(32'h200);
      retire(32'h204);
      retire(32'h210);
    end
    pulse_stop();
    expect_rd(1, 0, 255, "R6");
    expect_rd(1, 1, 255, "R6");
    drain();

    // R9: auto-start on CPU reset release
    pulse_clear();
    auto_start = 1'b1;
    cpu_rst_n  = 1'b0;
    idle(2);
    cpu_rst_n  = 1'b1;
    idle(1);
    check_valid(1'b0, "R9");
    retire(32'h100);
    retire(32'h104);
    retire(32'h110);
    pulse_stop();
    expect_rd(0, 0, 2, "R9");
    expect_rd(2, 0, 1, "R9");
    expect_rd(2, 1, 1, "R9");
    drain();

    // R9: disarmed auto-start ignores the release
    auto_start = 1'b0;
    cpu_rst_n  = 1'b0;
    idle(2);
    cpu_rst_n  = 1'b1;
    idle(2);
    check_valid(1'b1, "R9");
    retire(32'h100);
    retire(32'h110);
    expect_rd(0, 0, 2, "R9");
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule